// File: doc/BRIEF.md
# Sticky Event Alarm Aggregator

This block collects fault indications from three temperature channels, three fan channels, a watchdog and a software-requested event. It folds them into a single 8-bit alarm status word and drives an alert LED that blinks while any fault that needs attention is pending. Temperature and fan faults arrive as single-cycle pulses. Each pulse is latched into a per-channel sticky bit, which stays set until software clears that one channel with a write-one-to-clear access. The software event is a plain read/write flag in a control register.

Register writes use a simple write port: an enable, an address and a data byte. Every register value is presented continuously on output ports, so a surrounding bus adapter can read them without a separate read path. Live inputs drive the throttling and watchdog alarm bits directly. A slow blink tick from elsewhere in the chip paces the LED.

Top module: `sticky_alarm_hub`

## Requirements
- R1: After reset every temperature and fan sticky bit, the software event and the LED are 0, and the alarm word equals only its live bits (bit 7 throttle, bit 3 watchdog).
- R2: A pulse on `tempEvt[i]` sets bit 1 of temperature status register i (address 1+i, seen on `tempStatus[8*i +: 8]`) from the next cycle. The bit then stays set until a write to address 1+i with data bit 1 = 1. A write there with data bit 1 = 0 leaves it unchanged.
- R3: Bit 0 of temperature status register i follows `tempOk[i]` with no delay. All other temperature status bits except bits 0 and 1 read 0.
- R4: A pulse on `fanEvt[j]` sets bit 2 of fan status register j (address 4+j, seen on `fanStatus[8*j +: 8]`). The bit is cleared only by a write to address 4+j with data bit 2 = 1. All other fan status bits read 0.
- R5: When an event pulse and a clearing write for the same channel fall in the same cycle, the sticky bit is set afterwards.
- R6: A write to address 0 loads data bit 0 into the software event flag, shown as bit 0 of `ctrlReg`. Other data bits are ignored, and the other `ctrlReg` bits read 0.
- R7: The alarm word has bit 7 = `throttle` (live), bit 4 = software event, bit 3 = `wdogEvt` (live), bit 1 = OR of the three temperature sticky bits, bit 0 = OR of the three fan sticky bits. Bits 6, 5 and 2 are 0.
- R8: The flash condition is (alarm AND 0x13) != 0. While the condition holds, the LED toggles on each cycle with `blinkTick`. When the condition does not hold, the LED is 0 from the next cycle. Throttle and watchdog alone never light it.
- R9: A clearing write affects only the addressed channel. The sticky bits of all other channels keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tempEvt | input | 3 | Overtemperature event pulse per temperature channel |
| tempOk | input | 3 | Sensor-working flag per temperature channel |
| fanEvt | input | 3 | Fan fault pulse per fan channel |
| wdogEvt | input | 1 | Watchdog event level |
| throttle | input | 1 | CPU throttling active level |
| blinkTick | input | 1 | Slow blink pacing pulse |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register write address (0 control, 1-3 temperature, 4-6 fan) |
| wrData | input | 8 | Register write data |
| alarmReg | output | 8 | Alarm summary word |
| tempStatus | output | 24 | Temperature status registers, channel i in bits 8*i+7..8*i |
| fanStatus | output | 24 | Fan status registers, channel j in bits 8*j+7..8*j |
| ctrlReg | output | 8 | Control register (software event in bit 0) |
| alertLed | output | 1 | Alert LED drive |

## Verification
The collision of interest is an event pulse on a channel arriving in the same cycle as a write-one-to-clear to that same channel. The bench sweeps every channel through all combinations of prior sticky state, incoming pulse and clear-bit value, and expects the bit set whenever the pulse was present. A second overlap is a blink tick landing in the cycle that a clear removes the last flashing cause. The bench walks the LED through set and clear sequences with ticks on and off. It judges the result against a model that applies the flash rule to the state held before the edge.

// File: rtl/alarm_hub_pkg.sv
package alarm_hub_pkg;
  localparam int NUM_TEMP  = 3;
  localparam int NUM_FAN   = 3;
  localparam int REG_W     = 8;
  localparam int TEMP_BASE = 1;
  localparam int FAN_BASE  = TEMP_BASE + NUM_TEMP;
  localparam int NUM_REGS  = FAN_BASE + NUM_FAN;
  localparam int ADDR_W    = $clog2(NUM_REGS);

  // alarm word bit positions
  localparam int ALM_THROTTLE = 7;
  localparam int ALM_SW       = 4;
  localparam int ALM_WDOG     = 3;
  localparam int ALM_THERM    = 1;
  localparam int ALM_FAN      = 0;
  // status register bit positions
  localparam int TST_EVT = 1;
  localparam int TST_OK  = 0;
  localparam int FST_EVT = 2;
  localparam int CTL_SW  = 0;

  typedef struct packed {
    logic                swWr;
    logic                swVal;
    logic [NUM_TEMP-1:0] tempClr;
    logic [NUM_FAN-1:0]  fanClr;
  } hubStrobes_t;
endpackage

// File: rtl/alarm_hub_ctrl.sv
module alarm_hub_ctrl
  import alarm_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output hubStrobes_t       strobes
);

  always_comb begin
    strobes       = '0;
    strobes.swWr  = wrEn && (wrAddr == ADDR_W'(0));
    strobes.swVal = wrData[CTL_SW];
    for (int i = 0; i < NUM_TEMP; i++)
      strobes.tempClr[i] = wrEn && (wrAddr == ADDR_W'(TEMP_BASE + i)) && wrData[TST_EVT];
    for (int j = 0; j < NUM_FAN; j++)
      strobes.fanClr[j] = wrEn && (wrAddr == ADDR_W'(FAN_BASE + j)) && wrData[FST_EVT];
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.swWr, strobes.tempClr, strobes.fanClr})); // R9
  AST_WR_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !$isunknown({wrAddr, wrData})); // R6

endmodule

// File: rtl/alarm_hub_dpath.sv
module alarm_hub_dpath
  import alarm_hub_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  hubStrobes_t               strobes,
  input  logic [NUM_TEMP-1:0]       tempEvt,
  input  logic [NUM_TEMP-1:0]       tempOk,
  input  logic [NUM_FAN-1:0]        fanEvt,
  input  logic                      wdogEvt,
  input  logic                      throttle,
  input  logic                      blinkTick,
  output logic [REG_W-1:0]          alarmReg,
  output logic [NUM_TEMP*REG_W-1:0] tempStatus,
  output logic [NUM_FAN*REG_W-1:0]  fanStatus,
  output logic [REG_W-1:0]          ctrlReg,
  output logic                      alertLed
);

  logic [NUM_TEMP-1:0] tempSticky;
  logic [NUM_FAN-1:0]  fanSticky;
  logic                swEvt;
  logic                flash;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TEMP; gi++) begin : g_temp
      always_ff @(posedge clk) begin
        if (!rstN) tempSticky[gi] <= 1'b0;
        else       tempSticky[gi] <= tempEvt[gi] | (tempSticky[gi] & ~strobes.tempClr[gi]);
      end
      AST_TEMP_EVT_WINS: assert property (@(posedge clk) disable iff (!rstN)
        tempEvt[gi] |=> tempSticky[gi]); // R5
      AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (tempSticky[gi] && !strobes.tempClr[gi]) |=> tempSticky[gi]); // R2
      AST_TEMP_CLR: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.tempClr[gi] && !tempEvt[gi]) |=> !tempSticky[gi]); // R9
    end
    for (gi = 0; gi < NUM_FAN; gi++) begin : g_fan
      always_ff @(posedge clk) begin
        if (!rstN) fanSticky[gi] <= 1'b0;
        else       fanSticky[gi] <= fanEvt[gi] | (fanSticky[gi] & ~strobes.fanClr[gi]);
      end
      AST_FAN_EVT_WINS: assert property (@(posedge clk) disable iff (!rstN)
        fanEvt[gi] |=> fanSticky[gi]); // R5
      AST_FAN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (fanSticky[gi] && !strobes.fanClr[gi]) |=> fanSticky[gi]); // R4
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             swEvt <= 1'b0;
    else if (strobes.swWr) swEvt <= strobes.swVal;
  end

  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swWr |=> (swEvt == $past(strobes.swVal))); // R6

  always_comb begin
    alarmReg               = '0;
    alarmReg[ALM_THROTTLE] = throttle;
    alarmReg[ALM_SW]       = swEvt;
    alarmReg[ALM_WDOG]     = wdogEvt;
    alarmReg[ALM_THERM]    = |tempSticky;
    alarmReg[ALM_FAN]      = |fanSticky;
  end

  assign flash = (alarmReg & REG_W'(8'h13)) != '0;

  always_ff @(posedge clk) begin
    if (!rstN)          alertLed <= 1'b0;
    else if (!flash)    alertLed <= 1'b0;
    else if (blinkTick) alertLed <= ~alertLed;
  end

  AST_LED_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !(swEvt || (|tempSticky) || (|fanSticky)) |=> !alertLed); // R8
  AST_LED_PACE: assert property (@(posedge clk) disable iff (!rstN)
    !blinkTick |=> ($stable(alertLed) || !alertLed)); // R8

  always_comb begin
    tempStatus = '0;
    fanStatus  = '0;
    ctrlReg    = '0;
    for (int i = 0; i < NUM_TEMP; i++) begin
      tempStatus[i*REG_W + TST_EVT] = tempSticky[i];
      tempStatus[i*REG_W + TST_OK]  = tempOk[i];
    end
    for (int j = 0; j < NUM_FAN; j++)
      fanStatus[j*REG_W + FST_EVT] = fanSticky[j];
    ctrlReg[CTL_SW] = swEvt;
  end

endmodule

// File: rtl/sticky_alarm_hub.sv
module sticky_alarm_hub
  import alarm_hub_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_TEMP-1:0]       tempEvt,
  input  logic [NUM_TEMP-1:0]       tempOk,
  input  logic [NUM_FAN-1:0]        fanEvt,
  input  logic                      wdogEvt,
  input  logic                      throttle,
  input  logic                      blinkTick,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [REG_W-1:0]          wrData,
  output logic [REG_W-1:0]          alarmReg,
  output logic [NUM_TEMP*REG_W-1:0] tempStatus,
  output logic [NUM_FAN*REG_W-1:0]  fanStatus,
  output logic [REG_W-1:0]          ctrlReg,
  output logic                      alertLed
);

  hubStrobes_t strobes;

  alarm_hub_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobes (strobes)
  );

  alarm_hub_dpath dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tempEvt    (tempEvt),
    .tempOk     (tempOk),
    .fanEvt     (fanEvt),
    .wdogEvt    (wdogEvt),
    .throttle   (throttle),
    .blinkTick  (blinkTick),
    .alarmReg   (alarmReg),
    .tempStatus (tempStatus),
    .fanStatus  (fanStatus),
    .ctrlReg    (ctrlReg),
    .alertLed   (alertLed)
  );

endmodule

// File: tb/sticky_alarm_hub_tb.sv
module sticky_alarm_hub_tb_top;
  import alarm_hub_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_TEMP-1:0] tempEvt = '0;
  logic [NUM_TEMP-1:0] tempOk = '0;
  logic [NUM_FAN-1:0]  fanEvt = '0;
  logic wdogEvt = 1'b0, throttle = 1'b0, blinkTick = 1'b0, wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [REG_W-1:0]  wrData = '0;
  logic [REG_W-1:0]  alarmReg, ctrlReg;
  logic [NUM_TEMP*REG_W-1:0] tempStatus;
  logic [NUM_FAN*REG_W-1:0]  fanStatus;
  logic alertLed;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  logic [NUM_TEMP-1:0] mTemp = '0;
  logic [NUM_FAN-1:0]  mFan = '0;
  logic mSw = 1'b0, mLed = 1'b0;

  always #5 clk = ~clk;

  sticky_alarm_hub dut_i (
    .clk(clk), .rstN(rstN), .tempEvt(tempEvt), .tempOk(tempOk), .fanEvt(fanEvt),
    .wdogEvt(wdogEvt), .throttle(throttle), .blinkTick(blinkTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .alarmReg(alarmReg), .tempStatus(tempStatus),
    .fanStatus(fanStatus), .ctrlReg(ctrlReg), .alertLed(alertLed)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expAlarm();
    return {throttle, 2'b00, mSw, wdogEvt, 1'b0, |mTemp, |mFan};
  endfunction

  task automatic compareAll();
    check("R7 alarm", alarmReg, expAlarm());
    for (int i = 0; i < NUM_TEMP; i++) begin
      check("R2 temp sticky", tempStatus[i*8+1], mTemp[i]);
      check("R3 temp ok/zero", {tempStatus[i*8+7 -: 6], tempStatus[i*8]}, {6'b0, tempOk[i]});
    end
    for (int j = 0; j < NUM_FAN; j++)
      check("R4 fan status", fanStatus[j*8 +: 8], {5'b0, mFan[j], 2'b00});
    check("R6 ctrl", ctrlReg, {7'b0, mSw});
    check("R8 led", alertLed, mLed);
  endtask

  // apply current inputs for one edge, update model, drop pulses, compare
  task automatic step();
    logic flash;
    flash = mSw | (|mTemp) | (|mFan);
    for (int i = 0; i < NUM_TEMP; i++)
      mTemp[i] = tempEvt[i] | (mTemp[i] & ~(wrEn && wrAddr == ADDR_W'(1+i) && wrData[1]));
    for (int j = 0; j < NUM_FAN; j++)
      mFan[j] = fanEvt[j] | (mFan[j] & ~(wrEn && wrAddr == ADDR_W'(4+j) && wrData[2]));
    if (wrEn && wrAddr == '0) mSw = wrData[0];
    mLed = flash ? (blinkTick ? ~mLed : mLed) : 1'b0;
    @(posedge clk); #1;
    wrEn = 0; tempEvt = '0; fanEvt = '0; blinkTick = 0;
    compareAll();
  endtask

  task automatic doWrite(int addr, int data);
    wrEn = 1; wrAddr = ADDR_W'(addr); wrData = 8'(data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    // R1 reset state
    check("R1 alarm", alarmReg, 8'h00);
    check("R1 led", alertLed, 0);
    check("R1 temp", tempStatus, 0);
    check("R1 fan", fanStatus, 0);
    check("R1 ctrl", ctrlReg, 0);

    // temperature sweep: prior state x pulse x clear bit (R2, R5)
    for (int ch = 0; ch < NUM_TEMP; ch++)
      for (int pre = 0; pre < 2; pre++)
        for (int ev = 0; ev < 2; ev++)
          for (int wb = 0; wb < 2; wb++) begin
            if (pre != 0) begin tempEvt[ch] = 1; step(); end
            tempEvt[ch] = 1'(ev);
            doWrite(1+ch, (wb != 0) ? 8'h02 : 8'hFD);
            step();
            if (ev != 0) check("R5 temp collision", tempStatus[ch*8+1], 1);
            doWrite(1+ch, 8'h02); step();
          end

    // fan sweep (R4, R5)
    for (int ch = 0; ch < NUM_FAN; ch++)
      for (int pre = 0; pre < 2; pre++)
        for (int ev = 0; ev < 2; ev++)
          for (int wb = 0; wb < 2; wb++) begin
            if (pre != 0) begin fanEvt[ch] = 1; step(); end
            fanEvt[ch] = 1'(ev);
            doWrite(4+ch, (wb != 0) ? 8'h04 : 8'hFB);
            step();
            if (ev != 0) check("R5 fan collision", fanStatus[ch*8+2], 1);
            doWrite(4+ch, 8'h04); step();
          end

    // R9 per-channel clear independence
    for (int ch = 0; ch < NUM_TEMP; ch++) begin
      tempEvt = '1; fanEvt = '1; step();
      doWrite(1+ch, 8'hFF); step();
      for (int k = 0; k < NUM_TEMP; k++)
        check("R9 temp other", tempStatus[k*8+1], (k != ch) ? 1 : 0);
      check("R9 fan untouched", fanStatus, 24'h040404);
      doWrite(4+ch, 8'hFF); step();
      for (int k = 0; k < NUM_FAN; k++)
        check("R9 fan other", fanStatus[k*8+2], (k != ch) ? 1 : 0);
      for (int k = 0; k < NUM_TEMP; k++) begin doWrite(1+k, 8'h02); step(); end
      for (int k = 0; k < NUM_FAN; k++)  begin doWrite(4+k, 8'h04); step(); end
    end

    // R6 control write, extra bits ignored
    doWrite(0, 8'hFF); step();
    check("R6 sw set", ctrlReg, 8'h01);
    doWrite(0, 8'hFE); step();
    check("R6 sw clear", ctrlReg, 8'h00);
    doWrite(0, 8'h01); step();
    doWrite(0, 8'h00); step();

    // R3/R7 live level sweep
    for (int v = 0; v < 32; v++) begin
      tempOk = 3'(v); wdogEvt = v[3]; throttle = v[4];
      #1;
      check("R7 live alarm", alarmReg, expAlarm());
      check("R3 live ok", {tempStatus[16], tempStatus[8], tempStatus[0]}, v[2:0]);
      step();
    end

    // R8 watchdog and throttle alone never light LED
    wdogEvt = 1; throttle = 1;
    for (int k = 0; k < 4; k++) begin blinkTick = 1; step(); end
    check("R8 no flash wdog/throttle", alertLed, 0);

    // R8 blinking under each cause, ticks on and off
    for (int cause = 0; cause < 3; cause++) begin
      if (cause == 0) doWrite(0, 8'h01);
      else if (cause == 1) tempEvt[1] = 1;
      else fanEvt[2] = 1;
      step();
      for (int k = 0; k < 8; k++) begin blinkTick = 1'(k % 3 != 1); step(); end
      // clear the cause with a tick in the same cycle
      blinkTick = 1;
      if (cause == 0) doWrite(0, 8'h00);
      else if (cause == 1) doWrite(2, 8'h02);
      else doWrite(6, 8'h04);
      step();
      blinkTick = 1; step();
      check("R8 led dark after clear", alertLed, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule